// File: doc/BRIEF.md
# Serial Configuration Stream Reader

This block is the read side of a serial memory that holds configuration bit streams for an SRAM-based programmable logic device. The device being configured supplies a data clock, a chip-select and a combined reset/output-enable line. The block uses these to walk an address counter through one of four stored streams and presents one bit per data-clock edge. When its stream is used up, it releases the data line and pulls a cascade-out line low, so that a second memory chained behind it can carry on with the load.

Each stream is a page of `2**OFF_W` bits. The array holds four such pages. A two-bit page select, qualified by a page-enable input, picks the page. The choice is captured when readout starts and does not change until the next reset. A simple load port writes single bits into the array. It stands in for programming, which is outside this block.

There is no valid/ready handshake. The data clock paces the stream, and the receiver applies back-pressure only by raising chip-select, which stalls the counter and releases the line. A released data line is modelled by `data_en` low with `data_bit` forced to 0.

Top module: `cfg_stream_reader`

## Requirements
- R1: While `por_n` or `rst_oe_n` is low, whatever the level of `cs_n`, the address offset is cleared, `data_en` is 0 and `casc_n` is 1. These take effect at once, without waiting for a clock edge.
- R2: On the first rising `dclk` edge after reset is released, if `cs_n` is low, readout starts. From then on `data_en` is 1 and `data_bit` shows bit 0 of the selected page.
- R3: If `cs_n` is high at that first edge, the block stays disabled until the next reset. In that state `data_en` stays 0 and `casc_n` stays 1, even if `cs_n` later goes low.
- R4: During readout, each rising `dclk` edge with `cs_n` low advances the offset by one. `data_bit` then shows the next bit of the page.
- R5: During readout, while `cs_n` is high, `data_en` is 0 and the offset holds its value. When `cs_n` goes low again, output resumes at the same bit.
- R6: At the edge after the last bit of the page (offset `2**OFF_W-1`) has been shown, `casc_n` goes to 0 and `data_en` goes to 0. Both stay there until a reset.
- R7: With `page_en` high, the page is `page_sel`, sampled at the edge that starts readout. Bit k of the page is array address page*`2**OFF_W`+k. Changes to `page_sel` during readout have no effect.
- R8: With `page_en` low at the edge that starts readout, page 0 is read whatever `page_sel` is.
- R9: A rising `dclk` edge with `ld_we` high writes `ld_bit` into the array at `ld_addr`. The array address is {page, offset}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Data clock; all state changes on its rising edge |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_oe_n | input | 1 | Reset when low, output enable when high; asynchronous |
| cs_n | input | 1 | Chip-select, active low |
| page_en | input | 1 | Qualifies `page_sel`; when low, page 0 is used |
| page_sel | input | 2 | Page (stream) index |
| ld_we | input | 1 | Array write strobe |
| ld_addr | input | OFF_W+2 | Array write address |
| ld_bit | input | 1 | Array write data |
| data_bit | output | 1 | Serial data, valid when `data_en` is 1 |
| data_en | output | 1 | Output driver enable; 0 means high impedance |
| casc_n | output | 1 | Cascade-out, low once the stream is exhausted |

## Verification
Reset effects and the chip-select gating of `data_en` are combinational, so they are due within the same cycle as the input change. The bench samples them 1 ns after it changes the input. Every counter or state change lands on the next rising `dclk` edge and is visible in the bit shown after it. The bench therefore drives inputs at the falling edge and reads outputs at the following falling edge. As a result, bit k of a page is checked k+1 falling edges after reset is released, and `casc_n` is checked one edge after the last bit.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  typedef enum logic [1:0] {
    SR_IDLE = 2'd0,
    SR_LOCK = 2'd1,
    SR_READ = 2'd2,
    SR_DONE = 2'd3
  } sr_state_e;
  localparam int PAGE_SEL_W = 2;
endpackage

// File: rtl/cfg_stream_array.sv
module cfg_stream_array #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] cells;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr == ADDR_W'(g))) cells[g] <= wr_bit;
    end
  end

  assign rd_bit = cells[rd_addr];
endmodule

// File: rtl/cfg_stream_seq.sv
module cfg_stream_seq
  import cfg_stream_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic                  clk,
  input  logic                  arst_n,
  input  logic                  cs_n,
  input  logic [PAGE_SEL_W-1:0] page_eff,
  output logic [PAGE_SEL_W-1:0] page_q,
  output logic [OFF_W-1:0]      off_q,
  output logic                  reading,
  output logic                  done
);
  localparam logic [OFF_W-1:0] OFF_LAST = {OFF_W{1'b1}};

  sr_state_e state_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= SR_IDLE;
      off_q   <= '0;
      page_q  <= '0;
    end else begin
      case (state_q)
        SR_IDLE: begin
          if (!cs_n) begin
            state_q <= SR_READ;
            page_q  <= page_eff;
            off_q   <= '0;
          end else begin
            state_q <= SR_LOCK;
          end
        end
        SR_READ: begin
          if (!cs_n) begin
            if (off_q == OFF_LAST) state_q <= SR_DONE;
            else                   off_q   <= off_q + 1'b1;
          end
        end
        default: state_q <= state_q;
      endcase
    end
  end

  assign reading = (state_q == SR_READ);
  assign done    = (state_q == SR_DONE);

  AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (!arst_n)
    (reading && !cs_n && off_q != OFF_LAST) |=> (off_q == $past(off_q) + 1'b1)); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    (reading && cs_n) |=> $stable(off_q)); // R5
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!arst_n)
    reading |=> $stable(page_q)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!arst_n)
    done |=> done); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == SR_LOCK) |=> (state_q == SR_LOCK)); // R3
endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
  import cfg_stream_pkg::*;
#(
  parameter int OFF_W  = 4,
  localparam int ADDR_W = OFF_W + PAGE_SEL_W
) (
  input  logic                  dclk,
  input  logic                  por_n,
  input  logic                  rst_oe_n,
  input  logic                  cs_n,
  input  logic                  page_en,
  input  logic [PAGE_SEL_W-1:0] page_sel,
  input  logic                  ld_we,
  input  logic [ADDR_W-1:0]     ld_addr,
  input  logic                  ld_bit,
  output logic                  data_bit,
  output logic                  data_en,
  output logic                  casc_n
);
  logic                  arst_n;
  logic [PAGE_SEL_W-1:0] page_eff;
  logic [PAGE_SEL_W-1:0] page_q;
  logic [OFF_W-1:0]      off_q;
  logic                  reading;
  logic                  done;
  logic                  rd_bit;

  assign arst_n   = por_n & rst_oe_n;
  assign page_eff = page_en ? page_sel : '0;

  cfg_stream_seq #(.OFF_W(OFF_W)) u_seq (
    .clk      (dclk),
    .arst_n   (arst_n),
    .cs_n     (cs_n),
    .page_eff (page_eff),
    .page_q   (page_q),
    .off_q    (off_q),
    .reading  (reading),
    .done     (done)
  );

  cfg_stream_array #(.ADDR_W(ADDR_W)) u_array (
    .clk     (dclk),
    .wr_en   (ld_we),
    .wr_addr (ld_addr),
    .wr_bit  (ld_bit),
    .rd_addr ({page_q, off_q}),
    .rd_bit  (rd_bit)
  );

  assign data_en  = arst_n & reading & ~cs_n;
  assign data_bit = data_en & rd_bit;
  assign casc_n   = ~(arst_n & done);

  AST_CASC_RELEASES: assert property (@(posedge dclk) disable iff (!arst_n)
    !casc_n |-> !data_en); // R6
  AST_CS_GATES: assert property (@(posedge dclk) disable iff (!arst_n)
    cs_n |-> !data_en); // R5
endmodule

// File: tb/cfg_stream_reader_tb.sv
module cfg_stream_reader_tb;
  localparam int OFF_W = 4;
  localparam int PLEN  = 1 << OFF_W;
  localparam int AW    = OFF_W + 2;

  logic dclk = 0;
  logic por_n = 0, rst_oe_n = 0, cs_n = 0, page_en = 0;
  logic [1:0] page_sel = 0;
  logic ld_we = 0, ld_bit = 0;
  logic [AW-1:0] ld_addr = 0;
  logic data_bit, data_en, casc_n;

  int n_run = 0, n_fail = 0;

  always #2.5 dclk = ~dclk;

  cfg_stream_reader #(.OFF_W(OFF_W)) u_dut (
    .dclk(dclk), .por_n(por_n), .rst_oe_n(rst_oe_n), .cs_n(cs_n),
    .page_en(page_en), .page_sel(page_sel), .ld_we(ld_we),
    .ld_addr(ld_addr), .ld_bit(ld_bit), .data_bit(data_bit),
    .data_en(data_en), .casc_n(casc_n));

  function automatic logic pat(int a);
    logic [7:0] v = 8'((a * 13 + 5) ^ (a >> 2));
    return ^(v & 8'hB7);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic en, input logic bt, input logic cn);
    chk(data_en === en && casc_n === cn && (!en || data_bit === bt), req,
        {data_en, data_bit, casc_n}, {en, bt, cn});
  endtask

  // {page_en, page_sel, expected page}
  localparam logic [4:0] VEC [5] = '{
    {1'b1, 2'd0, 2'd0}, {1'b1, 2'd1, 2'd1}, {1'b1, 2'd2, 2'd2},
    {1'b1, 2'd3, 2'd3}, {1'b0, 2'd3, 2'd0}};

  task automatic do_reset(input logic csv);
    @(negedge dclk);
    rst_oe_n = 0; cs_n = csv;
    #1 chk_out("R1", 1'b0, 1'b0, 1'b1);
    @(negedge dclk);
    rst_oe_n = 1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1 chk_out("R1", 1'b0, 1'b0, 1'b1);
    // R9: load array while held in reset
    for (int a = 0; a < 4 * PLEN; a++) begin
      @(negedge dclk);
      ld_we = 1; ld_addr = AW'(a); ld_bit = pat(a);
    end
    @(negedge dclk);
    ld_we = 0; por_n = 1;

    for (int v = 0; v < 5; v++) begin
      page_en = VEC[v][4]; page_sel = VEC[v][3:2];
      do_reset(1'b0);
      for (int k = 0; k < PLEN; k++) begin
        @(negedge dclk);
        chk_out(k == 0 ? "R2/R7/R8/R9" : "R4/R7", 1'b1,
                pat(int'(VEC[v][1:0]) * PLEN + k), 1'b1);
        if (k == 3) page_sel = ~page_sel;   // R7: ignored mid-run
      end
      @(negedge dclk);
      chk_out("R6", 1'b0, 1'b0, 1'b0);
      @(negedge dclk);
      chk_out("R6", 1'b0, 1'b0, 1'b0);
    end

    // R1: reset out of the exhausted state restores casc_n
    @(negedge dclk);
    rst_oe_n = 0; cs_n = 1;
    #1 chk_out("R1", 1'b0, 1'b0, 1'b1);

    // R3: chip-select high at release locks the block out
    page_en = 1; page_sel = 2'd1;
    do_reset(1'b1);
    @(negedge dclk);
    chk_out("R3", 1'b0, 1'b0, 1'b1);
    cs_n = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge dclk);
      chk_out("R3", 1'b0, 1'b0, 1'b1);
    end

    // R5: stall on chip-select mid-stream, then resume at same bit
    page_sel = 2'd2;
    do_reset(1'b0);
    @(negedge dclk); chk_out("R2", 1'b1, pat(2 * PLEN + 0), 1'b1);
    @(negedge dclk); chk_out("R4", 1'b1, pat(2 * PLEN + 1), 1'b1);
    cs_n = 1;
    #1 chk_out("R5", 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge dclk);
    chk_out("R5", 1'b0, 1'b0, 1'b1);
    cs_n = 0;
    #1 chk_out("R5", 1'b1, pat(2 * PLEN + 1), 1'b1);
    @(negedge dclk); chk_out("R5", 1'b1, pat(2 * PLEN + 2), 1'b1);

    // R1: reset mid-stream with chip-select high clears the counter
    rst_oe_n = 0; cs_n = 1;
    #1 chk_out("R1", 1'b0, 1'b0, 1'b1);
    page_sel = 2'd3;
    @(negedge dclk);
    rst_oe_n = 1; cs_n = 0;
    @(negedge dclk); chk_out("R1", 1'b1, pat(3 * PLEN + 0), 1'b1);

    // R1: power-on reset alone also clears
    por_n = 0;
    #1 chk_out("R1", 1'b0, 1'b0, 1'b1);
    @(negedge dclk);
    por_n = 1;
    @(negedge dclk); chk_out("R1", 1'b1, pat(3 * PLEN + 0), 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule